// File: doc/BRIEF.md
# Vertical Sync and Field Parity Detector

This block watches a digital, already synchronised, active-low composite sync stream and picks out the field-blanking interval. It measures the width of every low pulse in units of a scaled time tick and sorts it into one of three classes: equalising (narrow), line sync (medium) or broad field-sync (wide). The first broad pulse starts an active-low vertical sync pulse on its trailing edge. That pulse then runs until the second narrow pulse that follows. When a format has one long low period with no serration notches, a default-delay timer starts the vertical pulse while the sync is still low. A timeout ends a vertical pulse that sees no narrow pulses.

A free-running line-phase counter is re-locked on every line-class pulse. The detector uses it to decide whether the launching broad pulse began on a whole-line boundary (odd field) or half-way through a line (even field). It latches that decision at the moment vertical sync starts. One shared timing-scale input sets the tick period, so every threshold moves together when the line rate changes.

Top module: `field_sync_detect`

## Requirements
- R1: After reset, vsyncN is 1 and oddField is 0.
- R2: A low pulse measuring at most 3 ticks (equalising class) or 4 to 11 ticks (line class) never starts vertical sync.
- R3: When a low pulse of at least 12 ticks (broad class) ends while the detector is armed, vsyncN goes to 0 on the first clock edge at which csyncN is seen high again.
- R4: Further broad pulses while vsyncN is 0 neither end nor restart the vertical pulse.
- R5: After vertical sync has started, vsyncN returns to 1 on the clock edge at which the second equalising-class pulse after the start is seen to end.
- R6: At each vertical sync start, oddField is loaded with 1 if the falling edge of the launching pulse lay within 8 ticks of a whole multiple of 64 ticks after the falling edge of the most recent line-class pulse, and with 0 otherwise. It does not change at any other time.
- R7: A low period reaching 40 ticks starts vertical sync (with the same parity rule) without waiting for csyncN to rise.
- R8: If no second equalising pulse arrives, vsyncN returns to 1 once 192 ticks have passed since the start of vertical sync.
- R9: One tick lasts timeScale+1 clock cycles, and every width, delay and timeout above is counted in ticks.
- R10: Once a vertical pulse has ended, broad pulses and long low periods are ignored until a line-class pulse has been seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csyncN | input | 1 | Synchronised active-low composite sync |
| timeScale | input | SCALE_W (4) | Tick period minus one, in clock cycles |
| vsyncN | output | 1 | Active-low vertical sync |
| oddField | output | 1 | 1 during odd fields, 0 during even fields |

## Verification
The bench uses the default parameters: a 64-tick line, classes split at 3 and 12 ticks, a 40-tick default delay and a 192-tick timeout. It runs mostly with timeScale set to 1, and then with 3. With five or six equalising pulses ahead of the broad group, the launching edge falls on a half-line or a whole-line phase, so both parities and a parity change between fields are exercised. The same 30-cycle low pulse counts as broad at timeScale 1 and as line sync at timeScale 3, which shows the scaling directly. Serrated, unserrated and timeout-terminated fields are all driven, and so is a broad pulse sent before re-arming.

// File: rtl/field_sync_pkg.sv
package field_sync_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic vsClr;   // restart the vertical-sync timer
    logic vsRun;   // let the vertical-sync timer advance
  } ctrlStrobeT;

  // per-cycle measurement results from datapath to control
  typedef struct packed {
    logic rise;       // csync low pulse just ended
    logic isEq;       // width of that pulse is equalising class
    logic isLine;     // width is line-sync class
    logic isBroad;    // width is broad class
    logic longHit;    // current low period just reached the default delay
    logic onLine;     // current/last low pulse started on a whole-line phase
    logic vsExpired;  // vertical-sync timeout reached
  } measT;

  typedef enum logic [1:0] {
    ST_ARMED  = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_HOLD   = 2'd2
  } fsmStateT;

endpackage

// File: rtl/field_sync_dp.sv
module field_sync_dp
  import field_sync_pkg::*;
#(
  parameter int SCALE_W       = 4,
  parameter int CNT_W         = 8,
  parameter int LINE_TICKS    = 64,
  parameter int EQ_MAX        = 3,
  parameter int BROAD_MIN     = 12,
  parameter int DEFAULT_DELAY = 40,
  parameter int PHASE_MARGIN  = 8,
  parameter int VS_TIMEOUT    = 192
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               csyncN,
  input  logic [SCALE_W-1:0] timeScale,
  input  ctrlStrobeT         strb,
  output measT               meas
);

  localparam int PH_W = $clog2(LINE_TICKS);
  localparam int TO_W = $clog2(VS_TIMEOUT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] EQ_LIM   = CNT_W'(EQ_MAX);
  localparam logic [CNT_W-1:0] BROAD_LIM = CNT_W'(BROAD_MIN);
  localparam logic [CNT_W-1:0] LONG_PRE = CNT_W'(DEFAULT_DELAY - 1);
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(LINE_TICKS - 1);
  localparam logic [PH_W-1:0]  PH_LO    = PH_W'(PHASE_MARGIN);
  localparam logic [PH_W-1:0]  PH_HI    = PH_W'(LINE_TICKS - PHASE_MARGIN);
  localparam logic [TO_W-1:0]  TO_LIM   = TO_W'(VS_TIMEOUT);

  logic               csyncD;
  logic [SCALE_W-1:0] preCnt;
  logic               tick;
  logic [CNT_W-1:0]   lowCnt;
  logic [PH_W-1:0]    phase;
  logic               fallOnLine;
  logic [TO_W-1:0]    vsTimer;
  logic               rise, fall, isEq, isLine, isBroad, nearLine, expired;

  assign tick     = (preCnt >= timeScale);
  assign rise     = csyncN & ~csyncD;
  assign fall     = ~csyncN & csyncD;
  assign isEq     = (lowCnt <= EQ_LIM);
  assign isBroad  = (lowCnt >= BROAD_LIM);
  assign isLine   = ~isEq & ~isBroad;
  assign nearLine = (phase < PH_LO) || (phase >= PH_HI);
  assign expired  = (vsTimer >= TO_LIM);

  // tick prescaler and edge history
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      csyncD <= 1'b1;
    end else begin
      preCnt <= tick ? '0 : preCnt + 1'b1;
      csyncD <= csyncN;
    end
  end

  // low-width measurement, holds the width after the pulse ends
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                       lowCnt <= '0;
    else if (fall)                                   lowCnt <= '0;
    else if (!csyncN && tick && lowCnt != CNT_MAX)   lowCnt <= lowCnt + 1'b1;
  end

  // line phase, re-locked to the fall of every line-class pulse
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase      <= '0;
      fallOnLine <= 1'b0;
    end else begin
      if (rise && isLine)  phase <= PH_W'(lowCnt);
      else if (tick)       phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
      if (fall)            fallOnLine <= nearLine;
    end
  end

  // vertical-sync length timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              vsTimer <= '0;
    else if (strb.vsClr)                    vsTimer <= '0;
    else if (strb.vsRun && tick && !expired) vsTimer <= vsTimer + 1'b1;
  end

  always_comb begin
    meas.rise      = rise;
    meas.isEq      = isEq;
    meas.isLine    = isLine;
    meas.isBroad   = isBroad;
    meas.longHit   = !csyncN && !fall && tick && (lowCnt == LONG_PRE);
    meas.onLine    = fallOnLine;
    meas.vsExpired = expired;
  end

endmodule

// File: rtl/field_sync_ctrl.sv
module field_sync_ctrl
  import field_sync_pkg::*;
#(
  parameter int EQ_END = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  measT       meas,
  output ctrlStrobeT strb,
  output logic       vsyncN,
  output logic       oddField
);

  localparam int EQ_W = $clog2(EQ_END + 1);
  localparam logic [EQ_W-1:0] EQ_LAST = EQ_W'(EQ_END - 1);

  fsmStateT        state;
  logic [EQ_W-1:0] eqCnt;
  logic            launch, eqSeen;

  assign launch = (meas.rise && meas.isBroad) || meas.longHit;
  assign eqSeen = meas.rise && meas.isEq;

  always_comb begin
    strb.vsClr = (state == ST_ARMED) && launch;
    strb.vsRun = (state == ST_ACTIVE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_ARMED;
      eqCnt    <= '0;
      vsyncN   <= 1'b1;
      oddField <= 1'b0;
    end else begin
      unique case (state)
        ST_ARMED: if (launch) begin
          vsyncN   <= 1'b0;
          oddField <= meas.onLine;
          eqCnt    <= '0;
          state    <= ST_ACTIVE;
        end
        ST_ACTIVE: begin
          if (meas.vsExpired || (eqSeen && eqCnt == EQ_LAST)) begin
            vsyncN <= 1'b1;
            state  <= ST_HOLD;
          end else if (eqSeen) begin
            eqCnt <= eqCnt + 1'b1;
          end
        end
        ST_HOLD: if (meas.rise && meas.isLine) state <= ST_ARMED;
        default: state <= ST_HOLD;
      endcase
    end
  end

endmodule

// File: rtl/field_sync_detect.sv
module field_sync_detect
  import field_sync_pkg::*;
#(
  parameter int SCALE_W       = 4,
  parameter int CNT_W         = 8,
  parameter int LINE_TICKS    = 64,
  parameter int EQ_MAX        = 3,
  parameter int BROAD_MIN     = 12,
  parameter int DEFAULT_DELAY = 40,
  parameter int PHASE_MARGIN  = 8,
  parameter int VS_TIMEOUT    = 192,
  parameter int EQ_END        = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               csyncN,
  input  logic [SCALE_W-1:0] timeScale,
  output logic               vsyncN,
  output logic               oddField
);

  ctrlStrobeT strb;
  measT       meas;

  field_sync_dp #(
    .SCALE_W(SCALE_W), .CNT_W(CNT_W), .LINE_TICKS(LINE_TICKS),
    .EQ_MAX(EQ_MAX), .BROAD_MIN(BROAD_MIN), .DEFAULT_DELAY(DEFAULT_DELAY),
    .PHASE_MARGIN(PHASE_MARGIN), .VS_TIMEOUT(VS_TIMEOUT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .csyncN(csyncN), .timeScale(timeScale),
    .strb(strb), .meas(meas)
  );

  field_sync_ctrl #(.EQ_END(EQ_END)) u_ctrl (
    .clk(clk), .rstN(rstN), .meas(meas), .strb(strb),
    .vsyncN(vsyncN), .oddField(oddField)
  );

endmodule

// File: rtl/field_sync_chk.sv
module field_sync_chk #(
  parameter int SCALE_W    = 4,
  parameter int BROAD_MIN  = 12,
  parameter int VS_TIMEOUT = 192
) (
  input logic               clk,
  input logic               rstN,
  input logic               csyncN,
  input logic [SCALE_W-1:0] timeScale,
  input logic               vsyncN,
  input logic               oddField
);

  logic        prevCsync;
  logic [15:0] lowLen;
  logic [15:0] vsLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevCsync <= 1'b1;
      lowLen    <= '0;
      vsLen     <= '0;
    end else begin
      prevCsync <= csyncN;
      if (!csyncN) lowLen <= prevCsync ? 16'd1 : ((lowLen == 16'hFFFF) ? lowLen : lowLen + 16'd1);
      vsLen <= vsyncN ? 16'd0 : ((vsLen == 16'hFFFF) ? vsLen : vsLen + 16'd1);
    end
  end

  // R2
  broad_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(vsyncN) |-> (int'(lowLen) >= (BROAD_MIN - 2) * (int'(timeScale) + 1)));

  // R3
  launch_after_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(vsyncN) |-> !$past(csyncN, 2));

  // R6
  parity_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(oddField) |-> $fell(vsyncN));

  // R8
  vs_bounded_chk: assert property (@(posedge clk) disable iff (!rstN)
    !vsyncN |-> (int'(vsLen) <= (VS_TIMEOUT + 4) * (int'(timeScale) + 1)));

endmodule

bind field_sync_detect field_sync_chk #(
  .SCALE_W(SCALE_W), .BROAD_MIN(BROAD_MIN), .VS_TIMEOUT(VS_TIMEOUT)
) u_chk (.*);

// File: tb/field_sync_detect_bench.sv
module field_sync_detect_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       csyncN = 1'b1;
  logic [3:0] timeScale = 4'd1;
  logic       vsyncN;
  logic       oddField;
  int         total = 0;
  int         bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  field_sync_detect u_field_sync_detect (
    .clk(clk), .rstN(rstN), .csyncN(csyncN), .timeScale(timeScale),
    .vsyncN(vsyncN), .oddField(oddField)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  // hold csync at a level for n ticks (called at a negedge)
  task automatic holdTicks(input logic lvl, input int n);
    csyncN = lvl;
    repeat (n * (int'(timeScale) + 1)) @(negedge clk);
  endtask

  // release csync and check vsync just after the next clock edge
  task automatic riseCheck(input string tag, input logic expVs);
    csyncN = 1'b1;
    @(posedge clk);
    #1;
    chk(tag, vsyncN, expVs);
    @(negedge clk);
  endtask

  task automatic linePulse();
    holdTicks(1'b0, 5);
    holdTicks(1'b1, 59);
  endtask

  task automatic eqPulse(input string tag);
    holdTicks(1'b0, 2);
    holdTicks(1'b1, 30);
    chk(tag, vsyncN, 1'b1);
  endtask

  // serrated field: preEq equalisers set the phase of the broad group
  task automatic serratedField(input int preEq, input logic expOdd);
    repeat (4) linePulse();
    repeat (preEq) eqPulse("R2 equaliser ignored");
    holdTicks(1'b0, 27);
    chk("R3 not before trailing edge", vsyncN, 1'b1);
    riseCheck("R3 start on broad trailing edge", 1'b0);
    chk("R6 parity at start", oddField, expOdd);
    holdTicks(1'b1, 5);
    repeat (4) begin
      holdTicks(1'b0, 27);
      holdTicks(1'b1, 5);
    end
    chk("R4 held through broad group", vsyncN, 1'b0);
    holdTicks(1'b0, 2);
    riseCheck("R5 still low after first equaliser", 1'b0);
    holdTicks(1'b1, 30);
    holdTicks(1'b0, 2);
    riseCheck("R5 end at second equaliser", 1'b1);
    holdTicks(1'b1, 30);
    repeat (3) eqPulse("R5 stays high");
    chk("R6 parity held after end", oddField, expOdd);
  endtask

  task automatic rearmTest();
    holdTicks(1'b0, 27);
    riseCheck("R10 broad ignored before rearm", 1'b1);
    holdTicks(1'b1, 30);
    chk("R10 still high", vsyncN, 1'b1);
    repeat (2) linePulse();
    holdTicks(1'b0, 27);
    riseCheck("R10 broad accepted after line pulse", 1'b0);
    holdTicks(1'b1, 30);
    holdTicks(1'b0, 2);
    holdTicks(1'b1, 30);
    holdTicks(1'b0, 2);
    riseCheck("R5 end after rearm field", 1'b1);
    holdTicks(1'b1, 30);
  endtask

  task automatic unserratedField();
    repeat (4) linePulse();
    repeat (6) eqPulse("R2 equaliser ignored");
    holdTicks(1'b0, 38);
    chk("R7 not before default delay", vsyncN, 1'b1);
    holdTicks(1'b0, 4);
    chk("R7 default start while low", vsyncN, 1'b0);
    chk("R6 parity on default start", oddField, 1'b1);
    holdTicks(1'b0, 18);
    holdTicks(1'b1, 30);
    chk("R7 long pulse end no effect", vsyncN, 1'b0);
    holdTicks(1'b0, 2);
    riseCheck("R5 first equaliser", 1'b0);
    holdTicks(1'b1, 30);
    holdTicks(1'b0, 2);
    riseCheck("R5 end after unserrated", 1'b1);
    holdTicks(1'b1, 30);
  endtask

  task automatic timeoutField();
    repeat (4) linePulse();
    repeat (5) eqPulse("R2 equaliser ignored");
    holdTicks(1'b0, 42);
    chk("R7 default start", vsyncN, 1'b0);
    chk("R6 even parity", oddField, 1'b0);
    holdTicks(1'b0, 18);
    holdTicks(1'b1, 160);
    chk("R8 still low before timeout", vsyncN, 1'b0);
    holdTicks(1'b1, 22);
    chk("R8 ended by timeout", vsyncN, 1'b1);
    chk("R8 R10 held after timeout", oddField, 1'b0);
  endtask

  task automatic scaleTest();
    repeat (2) linePulse();
    timeScale = 4'd3;
    repeat (2) linePulse();
    csyncN = 1'b0;
    repeat (30) @(negedge clk);
    riseCheck("R9 30 cycles is line class at scale 3", 1'b1);
    holdTicks(1'b1, 40);
    chk("R9 no start at scale 3", vsyncN, 1'b1);
    timeScale = 4'd1;
    repeat (2) linePulse();
    csyncN = 1'b0;
    repeat (30) @(negedge clk);
    riseCheck("R9 30 cycles is broad at scale 1", 1'b0);
    holdTicks(1'b1, 30);
    holdTicks(1'b0, 2);
    holdTicks(1'b1, 30);
    holdTicks(1'b0, 2);
    riseCheck("R9 end at scale 1", 1'b1);
    holdTicks(1'b1, 30);
    timeScale = 4'd3;
    serratedField(6, 1'b1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 vsync idle after reset", vsyncN, 1'b1);
    chk("R1 parity clear after reset", oddField, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    serratedField(6, 1'b1);
    rearmTest();
    serratedField(5, 1'b0);
    unserratedField();
    timeoutField();
    scaleTest();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule